// File: doc/BRIEF.md
# Multi-Lane Periodic Flash Generator

This block drives a row of indicator outputs. Each lane blinks on its own programmed period, measured in pulses of a shared slow tick strobe. A lane starts blinking when its run request goes high. It turns its output on at once and then alternates between on and off intervals. Each interval lasts exactly the programmed number of ticks.

After each complete flash (one on interval followed by one off interval), the lane raises a one-cycle completion strobe. The strobe comes at the moment the output turns back on. Dropping the run request stops the lane at the next clock. It ends up dark and idle, and it does not report the interrupted flash.

Every lane holds its own interval counter. Lanes therefore never share timing, and the lane count is set by a single parameter. The tick strobe comes from outside the block, typically a divided-down millisecond pulse.

Top module: `flash_array`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every lane's `led` and `done` bits are 0 after that edge, and the lane is idle.
- R2: In the first clock cycle where a lane's `start` bit is high after being low (or after reset), that lane's `led` goes to 1 at the next rising edge, with `done` at 0.
- R3: Once a lane is running, its interval counter advances only on cycles where `tick` is 1. An interval ends on the tick that brings the count to P, where P is the lane's period field. Exactly P ticks are sampled while `led` holds each value.
- R4: While `start` stays high, `led` toggles at the end of every interval and holds its value between interval ends, so the flashing continues without limit.
- R5: `done` is a one-cycle pulse. It is raised at the edge where an off interval ends (`led` going from 0 to 1), and at no other time. Consecutive pulses are therefore 2·P ticks apart.
- R6: If a lane's `start` is low at a rising edge, that lane's `led` and `done` are 0 after the edge and its counter is cleared. The interrupted flash produces no `done`. A later restart begins a fresh, full on interval.
- R7: A period field of 0 behaves exactly like a period of 1.
- R8: Lane i uses only `start[i]` and bits `period[i*13 +: 13]`. Lanes with different periods and run requests do not affect each other.
- R9: If a lane's period is reduced below its current count while it runs, the running interval ends on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | LANES | Per-lane run request, level sensitive |
| tick | input | 1 | Shared time-base strobe, one cycle wide |
| period | input | LANES*PW | Per-lane interval length in ticks, lane i at bits [i*PW +: PW] |
| led | output | LANES | Per-lane flash output, 1 = on |
| done | output | LANES | Per-lane one-cycle flash-complete strobe |

## Verification
The block is first run with a tick on every cycle and lane periods of 1, 5, 300 and 0. This shows whether interval lengths are counted exactly, whether the zero period is handled, and whether each lane keeps its own period. A later run with the largest 13-bit period shows whether the counter covers its full range without wrapping early.

A long stretch follows with random tick density, random per-lane periods and random starts and stops. This exposes counting on non-tick cycles, leakage between lanes, and spurious `done` pulses on interrupted flashes. Directed cases cover the first on-cycle after a start, the clean stop, and a period reduced mid-interval. These separate the arming behaviour, the stop behaviour and the early interval end.

// File: rtl/flash_pkg.sv
// Package: shared widths and types for the flash generator.
// Assumes: period fields are unsigned tick counts.
package flash_pkg;
    localparam int PERIOD_W = 13;
    typedef logic [PERIOD_W-1:0] period_t;
endpackage

// File: rtl/interval_timer.sv
// Module: interval_timer
// Counts tick strobes while enabled and flags the last tick of each interval.
// Assumes: tick is a single-cycle strobe; a zero period is treated as one.
module interval_timer #(
    parameter int PW = flash_pkg::PERIOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [PW-1:0] period,
    output logic          wrap
);
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    logic [PW-1:0] cnt;
    logic [PW-1:0] limit;
    logic          at_end;

    // Clamp zero to one and form the terminal count.
    always_comb begin
        limit  = ((period == '0) ? ONE : period) - ONE;
        at_end = (cnt >= limit);
        wrap   = run && tick && at_end;
    end

    // Counter: held clear when idle, advances on ticks, restarts at interval end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + ONE;
        end
    end

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(cnt));

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/flash_phase.sv
// Module: flash_phase
// Holds the output phase of one lane: arms on start, toggles on interval end,
// strobes done when an off interval closes.
// Assumes: wrap comes from this lane's own interval timer.
module flash_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wrap,
    output logic armed,
    output logic led,
    output logic done
);
    // Phase register: idle, arm with output on, then toggle per interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            armed <= 1'b0;
            led   <= 1'b0;
            done  <= 1'b0;
        end else if (!armed) begin
            armed <= 1'b1;
            led   <= 1'b1;
            done  <= 1'b0;
        end else if (wrap) begin
            led   <= ~led;
            done  <= ~led;
        end else begin
            done  <= 1'b0;
        end
    end

    // R6
    stop_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !led && !done);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_with_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> led);

    // R4
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && armed && !wrap |=> $stable(led));
endmodule

// File: rtl/flash_lane.sv
// Module: flash_lane
// One independent flashing lane: its own timer plus its own phase register.
// Assumes: nothing is shared with other lanes except clock, reset and tick.
module flash_lane #(
    parameter int PW = flash_pkg::PERIOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic [PW-1:0] period,
    output logic          led,
    output logic          done
);
    logic armed;
    logic wrap;
    logic run;

    // Timer only runs once the lane has armed and while start holds.
    always_comb run = start && armed;

    interval_timer #(.PW(PW)) timer_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .period (period),
        .wrap   (wrap)
    );

    flash_phase phase_u (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .wrap  (wrap),
        .armed (armed),
        .led   (led),
        .done  (done)
    );
endmodule

// File: rtl/flash_array.sv
// Module: flash_array
// Top level: LANES independent flashing lanes sharing only clock, reset and tick.
// Assumes: period lane i sits at bits [i*PW +: PW].
module flash_array #(
    parameter int LANES = 4,
    parameter int PW    = flash_pkg::PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    start,
    input  logic                tick,
    input  logic [LANES*PW-1:0] period,
    output logic [LANES-1:0]    led,
    output logic [LANES-1:0]    done
);
    // One lane per generate iteration; R8 independence by construction of ownership.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        flash_lane #(.PW(PW)) lane_u (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start[i]),
            .tick   (tick),
            .period (period[i*PW +: PW]),
            .led    (led[i]),
            .done   (done[i])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> led == '0 && done == '0);
endmodule

// File: tb/flash_array_tb_top.sv
`timescale 1ns/1ps
module flash_array_tb_top;
    localparam int LANES = 4;
    localparam int PW    = 13;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES-1:0]    start = '0;
    logic                tick = 1'b0;
    logic [LANES*PW-1:0] period = '0;
    logic [LANES-1:0]    led;
    logic [LANES-1:0]    done;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference state, computed from the requirements
    bit      r_arm [LANES];
    int      r_cnt [LANES];
    bit      r_led [LANES];
    bit      r_done[LANES];
    // interval monitor state
    bit      m_prev[LANES];
    int      m_hi  [LANES];
    string   tag = "R1";

    always #2.5 clk = ~clk;

    flash_array #(.LANES(LANES), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .period(period), .led(led), .done(done)
    );

    function automatic int eff_period(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int lane_period(input int ln);
        return int'(period[ln*PW +: PW]);
    endfunction

    // reference update at each rising edge, inputs are stable there
    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < LANES; i++) begin
            if (!rst_n || !start[i]) begin
                r_arm[i] = 0; r_cnt[i] = 0; r_led[i] = 0; r_done[i] = 0;
            end else if (!r_arm[i]) begin
                r_arm[i] = 1; r_led[i] = 1; r_done[i] = 0; r_cnt[i] = 0;
            end else begin
                r_done[i] = 0;
                if (tick) begin
                    if (r_cnt[i] >= eff_period(lane_period(i)) - 1) begin
                        r_cnt[i]  = 0;
                        r_done[i] = !r_led[i];
                        r_led[i]  = !r_led[i];
                    end else begin
                        r_cnt[i]++;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare all lanes against the reference and run the on-interval tick monitor
    task automatic compare_all();
        for (int i = 0; i < LANES; i++) begin
            check(led[i] == r_led[i], tag, $sformatf("led lane%0d", i), led[i], r_led[i]);
            check(done[i] == r_done[i], "R5", $sformatf("done lane%0d", i), done[i], r_done[i]);
            if (!start[i] || !rst_n) begin
                m_hi[i] = 0;
            end else begin
                if (m_prev[i] && tick) m_hi[i]++;
                if (m_prev[i] && !led[i]) begin
                    // R3: exact tick count during one on interval
                    check(m_hi[i] == eff_period(lane_period(i)), "R3",
                          $sformatf("on ticks lane%0d", i), m_hi[i],
                          eff_period(lane_period(i)));
                    m_hi[i] = 0;
                end
                if (!m_prev[i] && led[i]) m_hi[i] = 0;
            end
            m_prev[i] = led[i];
        end
    endtask

    // one cycle: sample at falling edge, then drive next inputs
    task automatic step(input bit t);
        @(negedge clk);
        compare_all();
        tick = t;
    endtask

    function automatic void set_period(input int ln, input int p);
        period[ln*PW +: PW] = PW'(p);
    endfunction

    initial begin
        void'($urandom(32'h0BEE_F00D));
        for (int i = 0; i < LANES; i++) begin
            r_arm[i] = 0; r_cnt[i] = 0; r_led[i] = 0; r_done[i] = 0;
            m_prev[i] = 0; m_hi[i] = 0;
        end
        // R1: reset state
        repeat (4) @(negedge clk);
        check(led == '0 && done == '0, "R1", "reset outputs", int'({led, done}), 0);
        rst_n = 1'b1;
        step(1'b0);

        // R2: first on-cycle after start
        tag = "R2";
        set_period(0, 1); set_period(1, 5); set_period(2, 300); set_period(3, 0);
        start = '1;
        tick  = 1'b1;
        @(negedge clk);
        check(led == '1 && done == '0, "R2", "arm on", int'(led), 15);
        compare_all();

        // R4/R7: continuous flashing, tick every cycle, periods 1,5,300,0
        tag = "R4";
        for (int c = 0; c < 1800; c++) step(1'b1);
        tag = "R7";
        for (int c = 0; c < 40; c++) step(1'b1);

        // R6: stop mid-flash, no done, dark next clock, fresh restart
        tag = "R6";
        start[1] = 1'b0;
        @(negedge clk);
        check(led[1] == 1'b0 && done[1] == 1'b0, "R6", "stop dark", int'({led[1], done[1]}), 0);
        compare_all();
        for (int c = 0; c < 12; c++) begin
            step(1'b1);
            check(done[1] == 1'b0, "R6", "no done while stopped", done[1], 0);
        end
        start[1] = 1'b1;
        for (int c = 0; c < 40; c++) step(1'b1);

        // R9: shrink period of lane 2 while its count is high
        tag = "R9";
        for (int c = 0; c < 250; c++) step(1'b1);
        set_period(2, 3);
        for (int c = 0; c < 30; c++) step(1'b1);

        // R3: large period, full on interval at the top of the field
        tag = "R3";
        start = '0;
        step(1'b0);
        set_period(2, 8191);
        start = 4'b0100;
        for (int c = 0; c < 16500; c++) step(1'b1);

        // R8: random ticks, periods and start/stop per lane
        tag = "R8";
        for (int c = 0; c < 40000; c++) begin
            for (int i = 0; i < LANES; i++) begin
                if ($urandom % 250 == 0) begin
                    start[i] = ~start[i];
                    if (!start[i]) set_period(i, $urandom % 13);
                end
            end
            step(($urandom % 3) != 0);
        end

        // R1: reset again mid-run
        tag = "R1";
        start = '1;
        rst_n = 1'b0;
        @(negedge clk);
        check(led == '0 && done == '0, "R1", "reset mid-run", int'(led), 0);
        compare_all();
        rst_n = 1'b1;
        step(1'b0);
        step(1'b0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // watchdog: a hung run is a failed check and still prints the summary
    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog cycles actual=%0d expected=%0d", cycles, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule